// File: doc/BRIEF.md
# Multicast Destination Hash Filter

This block decides whether a received frame's destination address falls into the set of multicast groups the host has subscribed to. The receive path hands it the destination address one byte per cycle, in the order the bytes arrive on the wire. The block runs a serial CRC over those bytes and turns the resulting remainder into a 6-bit index. It then looks that index up in a 64-bit table and reports a hit or a miss.

Software owns the table, which is held as two 32-bit words. It adds a group by reading the word the group's index falls into, setting the one bit, and writing the word back. It clears the table by writing zero to both words. Frames whose first destination byte has bit 0 clear are not multicast. They skip the table and always report a miss.

Top module: `mchf_filter`

## Requirements
- R1: After a synchronous active-low reset, both table words read 0 and `match_valid` and `match_hit` are 0.
- R2: Each address is exactly six bytes, counted only on cycles where `addr_valid` is 1. The CRC starts from all ones and uses the reflected polynomial 0xEDB88320. Each byte is fed in least-significant bit first, and the count and CRC restart after the sixth byte.
- R3: The lookup index comes from the raw CRC remainder after the sixth byte, with no final complement. CRC bit 0 selects the word (0 or 1). CRC bits 1 to 5 give the bit position, with CRC bit 1 as the most significant bit of that position.
- R4: `match_valid` becomes 1 on the cycle after the sixth byte is accepted. It stays 1, with `match_hit` unchanged, until the first byte of the next address is accepted. It is 0 on the cycle after that byte.
- R5: For a multicast address (bit 0 of the first byte is 1), `match_hit` equals the table bit selected by R3.
- R6: For an address whose first byte has bit 0 clear, `match_hit` is 0 whatever the table holds.
- R7: When `tbl_we` is 1 on a clock edge, `tbl_wdata` replaces word `tbl_sel` and the other word is left as it was. `tbl_rdata` always shows word `tbl_sel`.
- R8: A read, OR in one bit, write back sequence keeps the bits set by earlier sequences, so every address added this way hits.
- R9: A lookup whose sixth byte arrives on the same clock edge as a table write sees the table as it was before that write.
- R10: Cycles with `addr_valid` at 0 between address bytes change neither the byte count nor the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_valid | input | 1 | `addr_byte` carries a destination address byte this cycle |
| addr_byte | input | 8 | Destination address byte, in wire order |
| match_valid | output | 1 | The result for the last complete address is available |
| match_hit | output | 1 | The last address was multicast and its table bit is set |
| tbl_we | input | 1 | Write `tbl_wdata` into the selected table word |
| tbl_sel | input | 1 | Table word select |
| tbl_wdata | input | 32 | Table write data |
| tbl_rdata | output | 32 | Contents of the selected table word |

## Verification
The assertions check, on every cycle, the local timing rules:
- the result appears one cycle after the final byte;
- the result holds through idle cycles;
- it clears once a new address begins;
- a non-multicast address never hits;
- a written word reads back.

Only the bench's reference model can show that the CRC and the index derivation point at the right table bit. It compares every cycle against a behavioural CRC. The bench scenarios also cover the rest:
- bits are preserved across read-modify-write adds;
- a lookup ignores a write landing on the same edge;
- gaps between bytes leave the result unchanged.

// File: rtl/mchf_pkg.sv
// Shared constants, types and the byte-wide CRC step for the multicast
// hash filter. Assumes a 32-bit reflected CRC fed LSB first.
package mchf_pkg;
    localparam int          CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

    typedef logic [CRC_W-1:0] crc_t;

    // Advance the remainder by one byte, bit 0 of the byte first.
    function automatic crc_t crc_step_byte(crc_t cur, logic [7:0] data);
        crc_t r;
        r = cur;
        for (int k = 0; k < 8; k++) begin
            if (r[0] ^ data[k]) r = (r >> 1) ^ CRC_POLY;
            else                r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/mchf_addr_seq.sv
// Byte sequencer: counts accepted address bytes, flags the first and the
// last byte, and remembers whether the address is multicast.
// Assumes ADDR_BYTES >= 2.
module mchf_addr_seq #(
    parameter int ADDR_BYTES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_valid,
    input  logic byte_lsb,
    output logic first_byte,
    output logic last_byte,
    output logic is_mcast
);
    localparam int CNT_W = $clog2(ADDR_BYTES);

    logic [CNT_W-1:0] cnt_q;
    logic             mcast_q;

    assign first_byte = (cnt_q == '0);
    assign last_byte  = (cnt_q == CNT_W'(ADDR_BYTES - 1));
    assign is_mcast   = first_byte ? byte_lsb : mcast_q;

    // Step the byte position on each accepted byte; wrap after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (byte_valid && last_byte)  cnt_q <= '0;
        else if (byte_valid)               cnt_q <= cnt_q + 1'b1;
    end

    // Capture the group bit from the first byte of each address.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mcast_q <= 1'b0;
        else if (byte_valid && first_byte)  mcast_q <= byte_lsb;
    end
endmodule

// File: rtl/mchf_crc_engine.sv
// Serial CRC over the address bytes, one byte per accepted cycle. The
// first byte of an address reseeds the remainder. The combinational
// next-remainder output lets the caller use the final value in the cycle
// of the last byte. Only the low OUT_W bits are exported.
module mchf_crc_engine
    import mchf_pkg::*;
#(
    parameter int OUT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic             first_byte,
    input  logic [7:0]       data,
    output logic [OUT_W-1:0] crc_low
);
    crc_t crc_q;
    crc_t crc_seed;
    crc_t crc_next;

    // Select the running remainder or a fresh seed, then fold in the byte.
    always_comb begin
        crc_seed = first_byte ? CRC_SEED : crc_q;
        crc_next = crc_step_byte(crc_seed, data);
    end

    assign crc_low = crc_next[OUT_W-1:0];

    // Hold the remainder between accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)          crc_q <= CRC_SEED;
        else if (byte_valid) crc_q <= crc_next;
    end
endmodule

// File: rtl/mchf_hash_index.sv
// Maps the low CRC bits onto a word select and a bit position as if the
// whole remainder were bit-reversed: CRC bit 0 is the top hash bit.
// Purely combinational.
module mchf_hash_index #(
    parameter int WSEL_W = 1,
    parameter int BSEL_W = 5
) (
    input  logic [WSEL_W+BSEL_W-1:0] crc_low,
    output logic [WSEL_W-1:0]        word_idx,
    output logic [BSEL_W-1:0]        bit_idx
);
    // Reverse the word-select field bit by bit.
    for (genvar m = 0; m < WSEL_W; m++) begin : g_wsel
        assign word_idx[WSEL_W-1-m] = crc_low[m];
    end
    // Reverse the bit-position field bit by bit.
    for (genvar m = 0; m < BSEL_W; m++) begin : g_bsel
        assign bit_idx[BSEL_W-1-m] = crc_low[WSEL_W+m];
    end
endmodule

// File: rtl/mchf_hash_table.sv
// Hash table held as TABLE_WORDS registers of WORD_W bits. It has one
// host word port for writes and combinational reads, and one lookup port
// that returns a single bit.
module mchf_hash_table #(
    parameter int TABLE_WORDS = 2,
    parameter int WORD_W      = 32,
    localparam int WSEL_W     = $clog2(TABLE_WORDS),
    localparam int BSEL_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [WSEL_W-1:0] lk_word,
    input  logic [BSEL_W-1:0] lk_bit,
    output logic              lk_hit
);
    logic [WORD_W-1:0] words_q [TABLE_WORDS];

    // One register per word; reset clears the table.
    for (genvar w = 0; w < TABLE_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                                 words_q[w] <= '0;
            else if (wr_en && wr_sel == WSEL_W'(w))     words_q[w] <= wr_data;
        end
    end

    assign rd_data = words_q[wr_sel];
    assign lk_hit  = words_q[lk_word][lk_bit];
endmodule

// File: rtl/mchf_filter.sv
// Multicast destination hash filter top. It takes six address bytes, one
// per accepted cycle, and registers a hit or miss one cycle after the
// last byte. The result holds until the next address begins. The table
// lookup sees the table as registered before any same-edge write.
module mchf_filter #(
    parameter int ADDR_BYTES  = 6,
    parameter int TABLE_WORDS = 2,
    parameter int WORD_W      = 32,
    localparam int WSEL_W     = $clog2(TABLE_WORDS),
    localparam int BSEL_W     = $clog2(WORD_W),
    localparam int IDX_W      = WSEL_W + BSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [7:0]        addr_byte,
    output logic              match_valid,
    output logic              match_hit,
    input  logic              tbl_we,
    input  logic [WSEL_W-1:0] tbl_sel,
    input  logic [WORD_W-1:0] tbl_wdata,
    output logic [WORD_W-1:0] tbl_rdata
);
    logic              first_byte, last_byte, is_mcast;
    logic [IDX_W-1:0]  crc_low;
    logic [WSEL_W-1:0] word_idx;
    logic [BSEL_W-1:0] bit_idx;
    logic              lk_hit;

    mchf_addr_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n), .byte_valid(addr_valid),
        .byte_lsb(addr_byte[0]), .first_byte(first_byte),
        .last_byte(last_byte), .is_mcast(is_mcast)
    );

    mchf_crc_engine #(.OUT_W(IDX_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .byte_valid(addr_valid),
        .first_byte(first_byte), .data(addr_byte), .crc_low(crc_low)
    );

    mchf_hash_index #(.WSEL_W(WSEL_W), .BSEL_W(BSEL_W)) u_idx (
        .crc_low(crc_low), .word_idx(word_idx), .bit_idx(bit_idx)
    );

    mchf_hash_table #(.TABLE_WORDS(TABLE_WORDS), .WORD_W(WORD_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_sel(tbl_sel),
        .wr_data(tbl_wdata), .rd_data(tbl_rdata),
        .lk_word(word_idx), .lk_bit(bit_idx), .lk_hit(lk_hit)
    );

    // Publish the result after the last byte; drop it when a new address starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_valid <= 1'b0;
            match_hit   <= 1'b0;
        end else if (addr_valid && last_byte) begin
            match_valid <= 1'b1;
            match_hit   <= is_mcast & lk_hit;
        end else if (addr_valid && first_byte) begin
            match_valid <= 1'b0;
            match_hit   <= 1'b0;
        end
    end
endmodule

// File: rtl/mchf_filter_checker.sv
// Cycle-level properties of the filter, observed at its ports. The checker
// keeps its own byte count and group flag to know where each address ends.
module mchf_filter_checker #(
    parameter int ADDR_BYTES  = 6,
    parameter int WSEL_W      = 1,
    parameter int WORD_W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_valid,
    input logic [7:0]        addr_byte,
    input logic              match_valid,
    input logic              match_hit,
    input logic              tbl_we,
    input logic [WSEL_W-1:0] tbl_sel,
    input logic [WORD_W-1:0] tbl_wdata,
    input logic [WORD_W-1:0] tbl_rdata
);
    localparam int CNT_W = $clog2(ADDR_BYTES);
    logic [CNT_W-1:0] ck_cnt;
    logic             ck_group;
    logic             ck_first, ck_last;

    assign ck_first = (ck_cnt == '0);
    assign ck_last  = (ck_cnt == CNT_W'(ADDR_BYTES - 1));

    // Independent byte position tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ck_cnt <= '0;
        else if (addr_valid && ck_last)  ck_cnt <= '0;
        else if (addr_valid)             ck_cnt <= ck_cnt + 1'b1;
    end

    // Remember the group bit of the address in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ck_group <= 1'b0;
        else if (addr_valid && ck_first)  ck_group <= addr_byte[0];
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!match_valid && !match_hit));

    p_result_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && ck_last) |=> match_valid);

    p_clear_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && ck_first) |=> !match_valid);

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> ($stable(match_valid) && $stable(match_hit)));

    p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |-> match_valid);

    p_unicast_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && ck_last && !ck_group) |=> !match_hit);

    p_write_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tbl_we) && tbl_sel == $past(tbl_sel)) |-> tbl_rdata == $past(tbl_wdata));
endmodule

bind mchf_filter mchf_filter_checker #(
    .ADDR_BYTES(ADDR_BYTES), .WSEL_W(WSEL_W), .WORD_W(WORD_W)
) u_mchf_chk (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .match_valid(match_valid), .match_hit(match_hit), .tbl_we(tbl_we),
    .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
);

// File: tb/mchf_filter_bench.sv
// Bench for the multicast hash filter: behavioural reference model checked
// every cycle, plus directed scenarios with their own checks.
module mchf_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        match_valid, match_hit;
    logic        tbl_we = 1'b0;
    logic [0:0]  tbl_sel = '0;
    logic [31:0] tbl_wdata = '0;
    logic [31:0] tbl_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mchf_filter u_mchf_filter (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .match_valid(match_valid), .match_hit(match_hit), .tbl_we(tbl_we),
        .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
    );

    typedef logic [7:0] mac_t [6];

    // Reference CRC over six bytes: reflected, LSB first, seeded with ones, no final complement.
    function automatic logic [31:0] ref_crc(mac_t a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++)
            for (int k = 0; k < 8; k++) begin
                logic fb = c[0] ^ a[i][k];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        return c;
    endfunction

    function automatic int ref_word(mac_t a);
        logic [31:0] c = ref_crc(a);
        return int'(c[0]);
    endfunction

    function automatic int ref_bit(mac_t a);
        logic [31:0] c = ref_crc(a);
        return 16*int'(c[1]) + 8*int'(c[2]) + 4*int'(c[3]) + 2*int'(c[4]) + int'(c[5]);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- reference model, updated on each rising edge ----------
    logic [7:0]  m_q [$];
    logic [31:0] m_tbl [2];
    int          m_cnt;
    logic        m_valid, m_hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q = {}; m_tbl[0] = 0; m_tbl[1] = 0; m_cnt = 0;
            m_valid = 0; m_hit = 0;
        end else begin
            logic [31:0] old_tbl [2];
            old_tbl = m_tbl;
            if (addr_valid) begin
                if (m_cnt == 0) begin
                    m_q = {}; m_valid = 0; m_hit = 0;
                end
                m_q.push_back(addr_byte);
                if (m_cnt == 5) begin
                    mac_t a;
                    for (int i = 0; i < 6; i++) a[i] = m_q[i];
                    m_valid = 1;
                    m_hit = a[0][0] && old_tbl[ref_word(a)][ref_bit(a)];
                    m_cnt = 0;
                end else m_cnt++;
            end
            if (tbl_we) m_tbl[tbl_sel] = tbl_wdata;
        end
    end

    // Compare outputs against the model a quarter period after each rising edge.
    always @(posedge clk) begin
        #5;
        if (!done) begin
            check("R4 model match_valid", 32'(match_valid), 32'(m_valid));
            check("R5 model match_hit", 32'(match_hit), 32'(m_hit));
            check("R7 model tbl_rdata", tbl_rdata, m_tbl[tbl_sel]);
        end
    end

    // ---------------- stimulus helpers --------------------------------------
    task automatic send_addr(mac_t a, int gap);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); addr_valid = 1; addr_byte = a[i];
            for (int g = 0; g < gap && i < 5; g++) begin
                @(negedge clk); addr_valid = 0; addr_byte = 8'hA5;
            end
        end
        @(negedge clk); addr_valid = 0;
        #1;
    endtask

    task automatic wr_word(int sel, logic [31:0] d);
        @(negedge clk); tbl_we = 1; tbl_sel = 1'(sel); tbl_wdata = d;
        @(negedge clk); tbl_we = 0;
        #1;
    endtask

    task automatic rd_word(int sel, output logic [31:0] d);
        tbl_sel = 1'(sel); #1; d = tbl_rdata;
    endtask

    // Software-style add: read, OR in the bit, write back.
    task automatic add_group(mac_t a);
        logic [31:0] w;
        rd_word(ref_word(a), w);
        w[ref_bit(a)] = 1'b1;
        wr_word(ref_word(a), w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog timeout");
        report();
    end

    initial begin
        mac_t ga = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
        mac_t gb = '{8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01};
        mac_t gc = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h0E};
        mac_t uc = '{8'h00, 8'h13, 8'h74, 8'h00, 8'h5C, 8'h38};
        logic [31:0] w, keep;

        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: table and outputs after reset
        rd_word(0, w); check("R1 word0 after reset", w, 0);
        rd_word(1, w); check("R1 word1 after reset", w, 0);
        check("R1 match_valid after reset", 32'(match_valid), 0);

        // R5: empty table, multicast misses; result valid right after the last byte (R4)
        send_addr(ga, 0);
        check("R4 valid after sixth byte", 32'(match_valid), 1);
        check("R5 miss on empty table", 32'(match_hit), 0);

        // R3/R5: add group A, then only the indexed bit is set and A hits
        add_group(ga);
        rd_word(ref_word(ga), w);
        check("R3 indexed bit set", w, 32'(1) << ref_bit(ga));
        send_addr(ga, 0);
        check("R5 hit after add", 32'(match_hit), 1);

        // R8: add B and C, A's bit still present, all hit
        rd_word(ref_word(ga), keep);
        add_group(gb);
        add_group(gc);
        rd_word(ref_word(ga), w);
        check("R8 earlier bit kept", w & keep, keep);
        send_addr(gb, 0); check("R8 group B hits", 32'(match_hit), 1);
        send_addr(gc, 0); check("R8 group C hits", 32'(match_hit), 1);
        send_addr(ga, 0); check("R8 group A still hits", 32'(match_hit), 1);

        // R2/R10: idle gaps between bytes give the same result
        send_addr(gb, 3);
        check("R10 gapped address hits", 32'(match_hit), 1);
        check("R2 six bytes complete", 32'(match_valid), 1);

        // R4: result holds while idle, clears after the next first byte
        repeat (5) @(negedge clk);
        #1;
        check("R4 held while idle", 32'(match_valid), 1);
        @(negedge clk); addr_valid = 1; addr_byte = 8'h01;
        @(negedge clk); addr_valid = 0; #1;
        check("R4 cleared on new start", 32'(match_valid), 0);
        for (int i = 1; i < 6; i++) begin
            @(negedge clk); addr_valid = 1; addr_byte = 8'(i);
        end
        @(negedge clk); addr_valid = 0; #1;
        check("R2 sequence realigned", 32'(match_valid), 1);

        // R6: full table, unicast misses, multicast hits
        wr_word(0, 32'hFFFF_FFFF);
        wr_word(1, 32'hFFFF_FFFF);
        send_addr(uc, 0);
        check("R6 unicast misses", 32'(match_hit), 0);
        check("R6 unicast still valid", 32'(match_valid), 1);

        // R7: writing one word leaves the other alone
        wr_word(0, 32'h1234_5678);
        rd_word(1, w); check("R7 other word untouched", w, 32'hFFFF_FFFF);
        rd_word(0, w); check("R7 written word", w, 32'h1234_5678);

        // R9: same-edge write seen only after the lookup
        wr_word(0, 0); wr_word(1, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); addr_valid = 1; addr_byte = ga[i];
        end
        @(negedge clk); addr_valid = 1; addr_byte = ga[5];
        tbl_we = 1; tbl_sel = 1'(ref_word(ga)); tbl_wdata = 32'hFFFF_FFFF;
        @(negedge clk); addr_valid = 0; tbl_we = 0; #1;
        check("R9 lookup ignores same-edge write", 32'(match_hit), 0);
        rd_word(ref_word(ga), w);
        check("R9 write landed", w, 32'hFFFF_FFFF);
        send_addr(ga, 1);
        check("R9 next lookup sees write", 32'(match_hit), 1);

        repeat (3) @(negedge clk);
        report();
    end
endmodule